// File: doc/BRIEF.md
# Token-Framed Bus Port Adapter

This block connects one protocol core to a port of a 9-bit internal bus. An arbiter on that bus moves framed messages between ports. Bit 8 of a bus word marks a control token. The protocol side uses plain 8-bit FIFOs, which saves storage. The adapter therefore adds the framing on the way in and removes it on the way out.

On the outbound path the arbiter writes words into the adapter. Only payload bytes are pushed into the protocol's transmit FIFO. Control tokens are discarded. A payload byte that arrives while that FIFO is full is dropped, and a sticky overflow flag is raised.

On the inbound path the protocol core writes bytes into its receive FIFO, which is a first-word-fall-through FIFO, and strobes the end of each packet. The adapter records the length of every finished packet and raises an available flag while at least one finished packet is waiting. The arbiter then pulses read enable, one word per pulse. Each pulse yields the next word of the frame: a begin token that carries the configured destination, the queued bytes, and then an end token. Every word appears exactly three cycles after the read enable that asked for it.

Top module: `tokbus_port_adapter`

## Requirements
- R1: A bus write whose bit 8 is 0 pushes its low 8 bits into the transmit FIFO (tx_push=1, tx_byte = bits 7:0) in the same cycle, provided tx_full is 0.
- R2: A bus write whose bit 8 is 1 is a control token. It never asserts tx_push, and it never sets the overflow flag, even when tx_full is 1.
- R3: A payload write made while tx_full is 1 is dropped (tx_push=0). tx_ovf goes to 1 on the next cycle and stays at 1 until reset.
- R4: While reset is applied and in the first cycle after it, tx_ovf, bus_avail, bus_rd_valid and tx_push are 0.
- R5: bus_avail is 1 only while at least one packet closed by rx_eop has not yet had its end token issued. It stays 0 while bytes are written without rx_eop, and it drops in the cycle after the last pending end token is issued.
- R6: A packet is delivered as three parts, in this order. First a begin token 9'b1_0ddddddd, where ddddddd is cfg_dest in the read cycle that issues it. Then each byte as 9'b0_bbbbbbbb, in write order. Last an end token 9'h180. An rx_eop that coincides with rx_wr includes that byte in the packet.
- R7: The word for a read-enable cycle appears on bus_rd_word with bus_rd_valid=1 exactly three cycles later. A read-enable cycle with no pending packet, and any cycle without read enable, gives bus_rd_valid=0 three cycles later.
- R8: Gaps in bus_rd_en partway through a packet neither lose nor repeat a word. The frame resumes where it stopped.
- R9: A packet closed with no bytes is delivered as a begin token followed directly by an end token.
- R10: Up to PKT_DEPTH closed packets wait in order. bus_avail stays 1 between them, and each packet is framed with its own length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_dest | input | 7 | Destination placed in issued begin tokens |
| bus_wr_en | input | 1 | Arbiter writes a word to this port |
| bus_wr_word | input | 9 | Written word, bit 8 = control token |
| tx_full | input | 1 | Transmit FIFO cannot take a byte |
| tx_push | output | 1 | Push tx_byte into the transmit FIFO |
| tx_byte | output | 8 | Payload byte for the transmit FIFO |
| tx_ovf | output | 1 | Sticky: a payload byte was dropped |
| bus_avail | output | 1 | A complete inbound packet is waiting |
| bus_rd_en | input | 1 | Arbiter requests the next inbound word |
| bus_rd_valid | output | 1 | bus_rd_word carries a word (3 cycles after request) |
| bus_rd_word | output | 9 | Inbound word to the bus |
| rx_wr | input | 1 | Protocol core wrote a byte into the receive FIFO |
| rx_eop | input | 1 | Protocol core closed the current packet |
| rx_empty | input | 1 | Receive FIFO is empty |
| rx_data | input | 8 | Head byte of the receive FIFO (fall-through) |
| rx_pop | output | 1 | Remove the head byte from the receive FIFO |

## Verification
A wrong frame phase or remaining-byte count shows on bus_rd_word three cycles after the read pulse that used it. It appears as a missing or duplicated byte, or as an end token in the wrong place. A miscounted packet counter or a wrong stored length shows at once on bus_avail: the flag rises before rx_eop, stays high after the last end token, or drops between queued packets. Faults on the outbound path show combinationally on tx_push in the cycle of the write, and on tx_ovf one cycle later.

// File: rtl/tokbus_pkg.sv
package tokbus_pkg;

    localparam int BYTE_W = 8;
    localparam int WORD_W = BYTE_W + 1;
    localparam int DEST_W = 7;
    localparam int RD_LAT = 3;

    localparam logic [BYTE_W-1:0] END_BODY = 8'h80;

    typedef struct packed {
        logic              ctl;
        logic [BYTE_W-1:0] body;
    } bus_word_t;

    typedef struct packed {
        logic      vld;
        bus_word_t w;
    } pipe_slot_t;

    typedef enum logic [1:0] {
        PH_BEGIN = 2'd0,
        PH_BODY  = 2'd1,
        PH_END   = 2'd2
    } frame_ph_t;

    function automatic bus_word_t make_begin(input logic [DEST_W-1:0] dest);
        bus_word_t r;
        r.ctl  = 1'b1;
        r.body = {1'b0, dest};
        return r;
    endfunction

    function automatic bus_word_t make_end();
        bus_word_t r;
        r.ctl  = 1'b1;
        r.body = END_BODY;
        return r;
    endfunction

    function automatic bus_word_t make_data(input logic [BYTE_W-1:0] b);
        bus_word_t r;
        r.ctl  = 1'b0;
        r.body = b;
        return r;
    endfunction

endpackage

// File: rtl/tokbus_tx_filter.sv
module tokbus_tx_filter
    import tokbus_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_word,
    input  logic              tx_full,
    output logic              tx_push,
    output logic [BYTE_W-1:0] tx_byte,
    output logic              tx_ovf
);

    bus_word_t w;
    logic      payload;
    logic      ovf_q;

    assign w       = bus_word_t'(wr_word);
    assign payload = wr_en & ~w.ctl;
    assign tx_push = payload & ~tx_full;
    assign tx_byte = w.body;
    assign tx_ovf  = ovf_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ovf_q <= 1'b0;
        end else if (payload && tx_full) begin
            ovf_q <= 1'b1;
        end
    end

    // R3
    tx_ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        tx_ovf |=> tx_ovf);

    // R2
    token_no_push_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_word[WORD_W-1]) |-> !tx_push);

endmodule

// File: rtl/tokbus_len_queue.sv
module tokbus_len_queue
    import tokbus_pkg::*;
#(
    parameter int PKT_DEPTH = 4,
    parameter int LEN_W     = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             byte_wr,
    input  logic             pkt_end,
    input  logic             pkt_done,
    output logic [LEN_W-1:0] head_len,
    output logic             pkt_ready
);

    localparam int PTR_W = (PKT_DEPTH > 1) ? $clog2(PKT_DEPTH) : 1;
    localparam int CNT_W = $clog2(PKT_DEPTH + 1);

    logic [LEN_W-1:0] len_mem [PKT_DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] pkt_cnt;
    logic [LEN_W-1:0] cur_len;
    logic [LEN_W-1:0] closing_len;

    assign closing_len = cur_len + LEN_W'(byte_wr);
    assign head_len    = len_mem[rd_ptr];
    assign pkt_ready   = (pkt_cnt != '0);

    always_ff @(posedge clk) begin
        if (pkt_end) begin
            len_mem[wr_ptr] <= closing_len;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            pkt_cnt <= '0;
            cur_len <= '0;
        end else begin
            if (pkt_end) begin
                wr_ptr  <= (wr_ptr == PTR_W'(PKT_DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
                cur_len <= '0;
            end else if (byte_wr) begin
                cur_len <= closing_len;
            end
            if (pkt_done) begin
                rd_ptr <= (rd_ptr == PTR_W'(PKT_DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            end
            case ({pkt_end, pkt_done})
                2'b10:   pkt_cnt <= pkt_cnt + 1'b1;
                2'b01:   pkt_cnt <= pkt_cnt - 1'b1;
                default: pkt_cnt <= pkt_cnt;
            endcase
        end
    end

    // R10
    pkt_cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        pkt_cnt <= CNT_W'(PKT_DEPTH));

    // R5
    done_needs_pkt_chk: assert property (@(posedge clk) disable iff (rst)
        pkt_done |-> pkt_ready);

endmodule

// File: rtl/tokbus_rx_framer.sv
module tokbus_rx_framer
    import tokbus_pkg::*;
#(
    parameter int LEN_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic [DEST_W-1:0] dest,
    input  logic              pkt_ready,
    input  logic [LEN_W-1:0]  head_len,
    input  logic              rx_empty,
    input  logic [BYTE_W-1:0] rx_data,
    output logic              rx_pop,
    output logic              pkt_done,
    output logic              emit_vld,
    output bus_word_t         emit_word
);

    frame_ph_t        ph;
    logic [LEN_W-1:0] rem;

    always_comb begin
        rx_pop    = 1'b0;
        pkt_done  = 1'b0;
        emit_vld  = 1'b0;
        emit_word = make_data(rx_data);
        if (rd_en) begin
            case (ph)
                PH_BEGIN: begin
                    emit_vld  = pkt_ready;
                    emit_word = make_begin(dest);
                end
                PH_BODY: begin
                    emit_vld  = 1'b1;
                    rx_pop    = 1'b1;
                end
                PH_END: begin
                    emit_vld  = 1'b1;
                    pkt_done  = 1'b1;
                    emit_word = make_end();
                end
                default: emit_vld = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph  <= PH_BEGIN;
            rem <= '0;
        end else if (rd_en) begin
            case (ph)
                PH_BEGIN: begin
                    if (pkt_ready) begin
                        rem <= head_len;
                        ph  <= (head_len == '0) ? PH_END : PH_BODY;
                    end
                end
                PH_BODY: begin
                    rem <= rem - 1'b1;
                    if (rem == LEN_W'(1)) begin
                        ph <= PH_END;
                    end
                end
                default: ph <= PH_BEGIN;
            endcase
        end
    end

    // R5
    pop_needs_packet_chk: assert property (@(posedge clk) disable iff (rst)
        rx_pop |-> (pkt_ready && !rx_empty));

endmodule

// File: rtl/tokbus_rd_pipe.sv
module tokbus_rd_pipe
    import tokbus_pkg::*;
#(
    parameter int STAGES = RD_LAT
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       in_vld,
    input  bus_word_t  in_word,
    output logic       out_vld,
    output bus_word_t  out_word
);

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        pipe_slot_t nxt;
        pipe_slot_t q;
        if (g == 0) begin : g_head
            assign nxt = '{vld: in_vld, w: in_word};
        end else begin : g_link
            assign nxt = g_stage[g-1].q;
        end
        always_ff @(posedge clk) begin
            if (rst) begin
                q <= '0;
            end else begin
                q <= nxt;
            end
        end
    end

    assign out_vld  = g_stage[STAGES-1].q.vld;
    assign out_word = g_stage[STAGES-1].q.w;

endmodule

// File: rtl/tokbus_port_adapter.sv
module tokbus_port_adapter
    import tokbus_pkg::*;
#(
    parameter int PKT_DEPTH = 4,
    parameter int LEN_W     = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DEST_W-1:0] cfg_dest,
    input  logic              bus_wr_en,
    input  logic [WORD_W-1:0] bus_wr_word,
    input  logic              tx_full,
    output logic              tx_push,
    output logic [BYTE_W-1:0] tx_byte,
    output logic              tx_ovf,
    output logic              bus_avail,
    input  logic              bus_rd_en,
    output logic              bus_rd_valid,
    output logic [WORD_W-1:0] bus_rd_word,
    input  logic              rx_wr,
    input  logic              rx_eop,
    input  logic              rx_empty,
    input  logic [BYTE_W-1:0] rx_data,
    output logic              rx_pop
);

    logic             pkt_ready;
    logic             pkt_done;
    logic [LEN_W-1:0] head_len;
    logic             emit_vld;
    bus_word_t        emit_word;
    bus_word_t        out_word;

    tokbus_tx_filter u_tx (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (bus_wr_en),
        .wr_word (bus_wr_word),
        .tx_full (tx_full),
        .tx_push (tx_push),
        .tx_byte (tx_byte),
        .tx_ovf  (tx_ovf)
    );

    tokbus_len_queue #(
        .PKT_DEPTH (PKT_DEPTH),
        .LEN_W     (LEN_W)
    ) u_lenq (
        .clk       (clk),
        .rst       (rst),
        .byte_wr   (rx_wr),
        .pkt_end   (rx_eop),
        .pkt_done  (pkt_done),
        .head_len  (head_len),
        .pkt_ready (pkt_ready)
    );

    tokbus_rx_framer #(
        .LEN_W (LEN_W)
    ) u_framer (
        .clk       (clk),
        .rst       (rst),
        .rd_en     (bus_rd_en),
        .dest      (cfg_dest),
        .pkt_ready (pkt_ready),
        .head_len  (head_len),
        .rx_empty  (rx_empty),
        .rx_data   (rx_data),
        .rx_pop    (rx_pop),
        .pkt_done  (pkt_done),
        .emit_vld  (emit_vld),
        .emit_word (emit_word)
    );

    tokbus_rd_pipe #(
        .STAGES (RD_LAT)
    ) u_pipe (
        .clk      (clk),
        .rst      (rst),
        .in_vld   (emit_vld),
        .in_word  (emit_word),
        .out_vld  (bus_rd_valid),
        .out_word (out_word)
    );

    assign bus_avail   = pkt_ready;
    assign bus_rd_word = out_word;

    // R7
    rd_latency_chk: assert property (@(posedge clk) disable iff (rst)
        bus_rd_valid |-> $past(bus_rd_en, 3));

endmodule

// File: tb/tokbus_port_adapter_tb_top.sv
module tokbus_port_adapter_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [6:0] cfg_dest = '0;
    logic       bus_wr_en = 1'b0;
    logic [8:0] bus_wr_word = '0;
    logic       tx_full = 1'b0;
    logic       tx_push;
    logic [7:0] tx_byte;
    logic       tx_ovf;
    logic       bus_avail;
    logic       bus_rd_en = 1'b0;
    logic       bus_rd_valid;
    logic [8:0] bus_rd_word;
    logic       rx_wr = 1'b0;
    logic       rx_eop = 1'b0;
    logic       rx_empty;
    logic [7:0] rx_data;
    logic       rx_pop;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    tokbus_port_adapter dut_i (
        .clk(clk), .rst(rst), .cfg_dest(cfg_dest),
        .bus_wr_en(bus_wr_en), .bus_wr_word(bus_wr_word), .tx_full(tx_full),
        .tx_push(tx_push), .tx_byte(tx_byte), .tx_ovf(tx_ovf),
        .bus_avail(bus_avail), .bus_rd_en(bus_rd_en),
        .bus_rd_valid(bus_rd_valid), .bus_rd_word(bus_rd_word),
        .rx_wr(rx_wr), .rx_eop(rx_eop), .rx_empty(rx_empty),
        .rx_data(rx_data), .rx_pop(rx_pop)
    );

    // receive FIFO model, fall-through
    logic [7:0] fmem [64];
    int wp = 0;
    int rp = 0;
    assign rx_empty = (wp == rp);
    assign rx_data  = fmem[rp[5:0]];
    always @(posedge clk) if (rx_pop) rp <= rp + 1;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    // write n bytes into the receive FIFO; close with rx_eop on the last byte if asked
    logic [7:0] pkt [8];
    task automatic send_bytes(input int n, input bit close);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            fmem[wp[5:0]] = pkt[i];
            wp = wp + 1;
            rx_wr  = 1'b1;
            rx_eop = close && (i == n - 1);
        end
        @(negedge clk);
        rx_wr  = 1'b0;
        rx_eop = 1'b0;
    endtask

    task automatic close_only();
        @(negedge clk);
        rx_eop = 1'b1;
        @(negedge clk);
        rx_eop = 1'b0;
    endtask

    logic [8:0] exp_w [16];
    int exp_n = 0;

    // drive read enable per pattern bit, check each output slot three cycles later
    task automatic read_run(input int n, input logic [31:0] pat, input string req);
        int  ptr;
        bit  hist [40];
        ptr = 0;
        for (int i = 0; i < n + 3; i++) begin
            @(negedge clk);
            if (i >= 3) begin
                if (hist[i-3] && ptr < exp_n) begin
                    chk(req, {23'd0, bus_rd_valid}, 32'd1);
                    chk(req, {23'd0, bus_rd_word}, {23'd0, exp_w[ptr]});
                    ptr++;
                end else begin
                    chk(req, {23'd0, bus_rd_valid}, 32'd0);
                end
            end
            hist[i]   = (i < n) ? pat[i] : 1'b0;
            bus_rd_en = hist[i];
        end
        bus_rd_en = 1'b0;
        chk(req, ptr, exp_n);
    endtask

    // outbound vectors: {wr_en, word[8:0], full, exp_push, exp_byte[7:0], exp_ovf}
    localparam logic [20:0] OUT_VEC [8] = '{
        {1'b1, 9'h041, 1'b0, 1'b1, 8'h41, 1'b0},  // R1 payload
        {1'b1, 9'h105, 1'b0, 1'b0, 8'h00, 1'b0},  // R2 begin token
        {1'b1, 9'h07E, 1'b0, 1'b1, 8'h7E, 1'b0},  // R1 payload
        {1'b0, 9'h033, 1'b0, 1'b0, 8'h00, 1'b0},  // no write
        {1'b1, 9'h180, 1'b0, 1'b0, 8'h00, 1'b0},  // R2 end token
        {1'b1, 9'h180, 1'b1, 1'b0, 8'h00, 1'b0},  // R2 token while full: no overflow
        {1'b1, 9'h099, 1'b1, 1'b0, 8'h00, 1'b1},  // R3 dropped
        {1'b1, 9'h010, 1'b0, 1'b1, 8'h10, 1'b1}   // R3 sticky, R1 still pushes
    };

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        // R4: during reset and just after
        repeat (2) @(negedge clk);
        chk("R4 ovf", {31'd0, tx_ovf}, 0);
        chk("R4 avail", {31'd0, bus_avail}, 0);
        chk("R4 valid", {31'd0, bus_rd_valid}, 0);
        do_reset();
        chk("R4 push", {31'd0, tx_push}, 0);
        chk("R4 avail after", {31'd0, bus_avail}, 0);

        // outbound table: R1 R2 R3
        for (int i = 0; i < 8; i++) begin
            logic [20:0] v;
            v = OUT_VEC[i];
            bus_wr_en   = v[20];
            bus_wr_word = v[19:11];
            tx_full     = v[10];
            #1;
            chk("R1/R2 push", {31'd0, tx_push}, {31'd0, v[9]});
            if (v[9]) chk("R1 byte", {24'd0, tx_byte}, {24'd0, v[8:1]});
            @(negedge clk);
            chk("R3 ovf", {31'd0, tx_ovf}, {31'd0, v[0]});
        end
        bus_wr_en = 1'b0;
        tx_full   = 1'b0;

        // R5 R6 R7: one packet, bytes first, closed later by a bare strobe
        cfg_dest = 7'h15;
        pkt[0] = 8'h11; pkt[1] = 8'h22; pkt[2] = 8'h33;
        send_bytes(3, 1'b0);
        chk("R5 no eop yet", {31'd0, bus_avail}, 0);
        close_only();
        chk("R5 avail on eop", {31'd0, bus_avail}, 1);
        exp_w[0] = 9'h115; exp_w[1] = 9'h011; exp_w[2] = 9'h022;
        exp_w[3] = 9'h033; exp_w[4] = 9'h180; exp_n = 5;
        read_run(6, 32'h3F, "R6/R7 frame");
        chk("R5 avail clears", {31'd0, bus_avail}, 0);

        // R7: read enable with nothing pending
        exp_n = 0;
        read_run(2, 32'h3, "R7 idle read");

        // R8: gaps in read enable, eop with the last byte
        cfg_dest = 7'h02;
        pkt[0] = 8'hC0; pkt[1] = 8'hC1; pkt[2] = 8'hC2; pkt[3] = 8'hC3;
        send_bytes(4, 1'b1);
        exp_w[0] = 9'h102; exp_w[1] = 9'h0C0; exp_w[2] = 9'h0C1;
        exp_w[3] = 9'h0C2; exp_w[4] = 9'h0C3; exp_w[5] = 9'h180; exp_n = 6;
        read_run(10, 32'b11_0011_0101, "R8 gapped read");
        chk("R8 avail clears", {31'd0, bus_avail}, 0);

        // R9: empty packet
        cfg_dest = 7'h7F;
        close_only();
        chk("R9 avail", {31'd0, bus_avail}, 1);
        exp_w[0] = 9'h17F; exp_w[1] = 9'h180; exp_n = 2;
        read_run(2, 32'h3, "R9 empty frame");
        chk("R9 avail clears", {31'd0, bus_avail}, 0);

        // R10: two queued packets, delivered in order
        cfg_dest = 7'h05;
        pkt[0] = 8'hA1; pkt[1] = 8'hA2;
        send_bytes(2, 1'b1);
        pkt[0] = 8'hB1;
        send_bytes(1, 1'b1);
        exp_w[0] = 9'h105; exp_w[1] = 9'h0A1; exp_w[2] = 9'h0A2; exp_w[3] = 9'h180;
        exp_n = 4;
        read_run(4, 32'hF, "R10 first");
        chk("R10 avail held", {31'd0, bus_avail}, 1);
        exp_w[0] = 9'h105; exp_w[1] = 9'h0B1; exp_w[2] = 9'h180; exp_n = 3;
        read_run(3, 32'h7, "R10 second");
        chk("R10 avail clears", {31'd0, bus_avail}, 0);

        // R3 R4: only reset clears the overflow flag
        chk("R3 ovf held", {31'd0, tx_ovf}, 1);
        do_reset();
        chk("R4 ovf cleared", {31'd0, tx_ovf}, 0);

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule